// File: doc/BRIEF.md
# Multiway Switch Branch Resolver

This block works out where a multiway switch instruction jumps to. A core hands it the code-unit address of the switch instruction, a signed 32-bit distance to the jump table (also counted in 16-bit code units), the 32-bit value under test and a one-cycle start strobe. The block then reads the table itself through a single-outstanding request/valid port into a 16-bit code memory. When it has finished it raises done for one cycle, together with a hit flag, the next program address and a flag for a malformed table.

Two table shapes are accepted, and the first code unit of the table tells them apart. A dense table covers a run of consecutive keys, so the slot is found by subtracting the lowest key. A sorted table lists its keys in ascending order with the targets after them, and the block finds the key by binary search. Every target is a signed offset from the switch instruction, not from the table. When no key matches, the next address is the instruction that follows the three-unit switch.

Top module: `swtab_dispatch`

## Requirements
- R1: After reset, done, hit, bad_tab and mem_req are all 0.
- R2: The table address T is sw_addr plus tab_off, taken modulo 2^ADDR_W. The first read goes to T (the identifier) and, for a valid identifier, the second read goes to T+1 (the 16-bit entry count n).
- R3: Every 32-bit table field is two code units: the low half at the lower address, the high half at the next address.
- R4: Identifier 0x0100 selects the dense table. The lowest key is at T+2 and target i is at T+4+2i. If d = test_val - lowest key (32-bit wrap), taken as unsigned, is below n, then hit=1 and new_pc = sw_addr + target d.
- R5: With a dense table whose d is not below n (this covers negative differences and n=0), hit=0 and new_pc = sw_addr + 3.
- R6: Identifier 0x0200 selects the sorted table. Key i is at T+2+2i and target i is at T+2+2n+2i, and the keys are compared as signed. If some key equals test_val, then hit=1 and new_pc = sw_addr + that key's target.
- R7: With a sorted table that holds no key equal to test_val, including n=0, hit=0 and new_pc = sw_addr + 3.
- R8: Any other identifier finishes the request after that single read, with bad_tab=1, hit=0 and new_pc = sw_addr + 3. A later start is then handled normally.
- R9: done is high for exactly one cycle per request. hit, bad_tab and new_pc change only in the cycle where done is high and keep their values until the next done.
- R10: At most one memory read is outstanding. A new request is issued only after mem_valid has answered the previous one, and no request is issued while the block is idle.
- R11: A request reads 1 code unit for a bad identifier, 4 for a dense miss and 6 for a dense hit. A sorted-table request reads at most 2 + 2*ceil(log2(n+1)) code units, plus 2 more on a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup; sampled only while idle |
| sw_addr | input | ADDR_W | Code-unit address of the switch instruction |
| tab_off | input | 32 | Signed code-unit offset from sw_addr to the table |
| test_val | input | 32 | Value being switched on |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Code-unit address of the read |
| mem_valid | input | 1 | Read data is present |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A table entry matched |
| new_pc | output | ADDR_W | Resolved next program address |
| bad_tab | output | 1 | The table identifier was not recognised |

## Verification
The bench builds the block with ADDR_W = 12 and backs it with a 4096-entry code memory whose read latency varies at random. The narrow address space lets negative table offsets, offsets many times larger than the space, tables that straddle the top of memory and targets that wrap the program address all occur with small numbers. With tables of up to 40 entries, the sorted search runs to depths of six probes. Keys near the signed extremes exercise the wrap of the dense index.

// File: rtl/swtab_pkg.sv
package swtab_pkg;
  localparam int CNT_W = 16;
  localparam logic [15:0] ID_DENSE  = 16'h0100;
  localparam logic [15:0] ID_SORTED = 16'h0200;

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_SZ, S_FKEY, S_SKEY, S_TGT
  } sw_state_t;

  typedef enum logic [1:0] {
    F_IDLE, F_LO, F_HI
  } fetch_state_t;
endpackage

// File: rtl/swtab_fetch.sv
module swtab_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [15:0]       mem_rdata,
  output logic              fin,
  output logic [31:0]       word
);
  import swtab_pkg::*;

  fetch_state_t st;
  logic         wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= F_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      wide_q   <= 1'b0;
      fin      <= 1'b0;
      word     <= '0;
    end else begin
      mem_req <= 1'b0;
      fin     <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          mem_req  <= 1'b1;
          mem_addr <= addr;
          wide_q   <= wide;
          st       <= F_LO;
        end
        F_LO: if (mem_valid) begin
          word <= {16'h0000, mem_rdata};
          if (wide_q) begin
            mem_req  <= 1'b1;
            mem_addr <= mem_addr + ADDR_W'(1);
            st       <= F_HI;
          end else begin
            fin <= 1'b1;
            st  <= F_IDLE;
          end
        end
        F_HI: if (mem_valid) begin
          word[31:16] <= mem_rdata;
          fin         <= 1'b1;
          st          <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swtab_search.sv
module swtab_search
  import swtab_pkg::*;
(
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] mid,
  input  logic [31:0]      key,
  input  logic [31:0]      probe,
  output logic             eq,
  output logic             exhausted,
  output logic [CNT_W-1:0] nlo,
  output logic [CNT_W-1:0] nhi,
  output logic [CNT_W-1:0] nmid
);
  logic below;

  always_comb begin
    eq    = (key == probe);
    below = ($signed(key) < $signed(probe));
    if (below) begin
      exhausted = (mid == lo);
      nlo       = lo;
      nhi       = mid - 1'b1;
    end else begin
      exhausted = (mid == hi);
      nlo       = mid + 1'b1;
      nhi       = hi;
    end
    nmid = CNT_W'(({1'b0, nlo} + {1'b0, nhi}) >> 1);
  end
endmodule

// File: rtl/swtab_dispatch.sv
module swtab_dispatch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [31:0]       tab_off,
  input  logic [31:0]       test_val,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [15:0]       mem_rdata,
  output logic              done,
  output logic              hit,
  output logic [ADDR_W-1:0] new_pc,
  output logic              bad_tab
);
  import swtab_pkg::*;

  localparam logic [ADDR_W-1:0] FALL_LEN = ADDR_W'(3);

  function automatic logic [ADDR_W-1:0] ua(input logic [31:0] v);
    return v[ADDR_W-1:0];
  endfunction

  sw_state_t         st;
  logic [ADDR_W-1:0] base, tab, faddr;
  logic [31:0]       keyr;
  logic [CNT_W-1:0]  size_q, lo, hi, mid;
  logic              dense_q, go, fwide;

  logic              fin;
  logic [31:0]       word;
  logic              eq, exhausted;
  logic [CNT_W-1:0]  nlo, nhi, nmid;

  logic [CNT_W-1:0]  sz_in, first_mid;
  logic [31:0]       dense_idx;
  logic              dense_in;
  logic [ADDR_W-1:0] tab_in, a_first_key, a_next_key, a_stgt, a_dtgt;

  swtab_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .addr(faddr), .wide(fwide),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .fin(fin), .word(word)
  );

  swtab_search u_search (
    .lo(lo), .hi(hi), .mid(mid), .key(keyr), .probe(word),
    .eq(eq), .exhausted(exhausted), .nlo(nlo), .nhi(nhi), .nmid(nmid)
  );

  always_comb begin
    tab_in      = sw_addr + ua(tab_off);
    sz_in       = word[CNT_W-1:0];
    first_mid   = CNT_W'(sz_in - 1'b1) >> 1;
    dense_idx   = keyr - word;
    dense_in    = dense_idx < 32'(size_q);
    a_first_key = tab + ua(32'd2 + (32'(first_mid) << 1));
    a_next_key  = tab + ua(32'd2 + (32'(nmid) << 1));
    a_stgt      = tab + ua(32'd2 + (32'(size_q) << 1) + (32'(mid) << 1));
    a_dtgt      = tab + ua(32'd4 + {dense_idx[30:0], 1'b0});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      base    <= '0;
      tab     <= '0;
      faddr   <= '0;
      keyr    <= '0;
      size_q  <= '0;
      lo      <= '0;
      hi      <= '0;
      mid     <= '0;
      dense_q <= 1'b0;
      go      <= 1'b0;
      fwide   <= 1'b0;
      done    <= 1'b0;
      hit     <= 1'b0;
      new_pc  <= '0;
      bad_tab <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base  <= sw_addr;
          keyr  <= test_val;
          tab   <= tab_in;
          faddr <= tab_in;
          fwide <= 1'b0;
          go    <= 1'b1;
          st    <= S_ID;
        end
        S_ID: if (fin) begin
          if (word[15:0] == ID_DENSE || word[15:0] == ID_SORTED) begin
            dense_q <= (word[15:0] == ID_DENSE);
            faddr   <= tab + ADDR_W'(1);
            fwide   <= 1'b0;
            go      <= 1'b1;
            st      <= S_SZ;
          end else begin
            done    <= 1'b1;
            hit     <= 1'b0;
            bad_tab <= 1'b1;
            new_pc  <= base + FALL_LEN;
            st      <= S_IDLE;
          end
        end
        S_SZ: if (fin) begin
          size_q <= sz_in;
          if (dense_q) begin
            faddr <= tab + ADDR_W'(2);
            fwide <= 1'b1;
            go    <= 1'b1;
            st    <= S_FKEY;
          end else if (sz_in == '0) begin
            done    <= 1'b1;
            hit     <= 1'b0;
            bad_tab <= 1'b0;
            new_pc  <= base + FALL_LEN;
            st      <= S_IDLE;
          end else begin
            lo    <= '0;
            hi    <= sz_in - 1'b1;
            mid   <= first_mid;
            faddr <= a_first_key;
            fwide <= 1'b1;
            go    <= 1'b1;
            st    <= S_SKEY;
          end
        end
        S_FKEY: if (fin) begin
          if (dense_in) begin
            faddr <= a_dtgt;
            fwide <= 1'b1;
            go    <= 1'b1;
            st    <= S_TGT;
          end else begin
            done    <= 1'b1;
            hit     <= 1'b0;
            bad_tab <= 1'b0;
            new_pc  <= base + FALL_LEN;
            st      <= S_IDLE;
          end
        end
        S_SKEY: if (fin) begin
          if (eq) begin
            faddr <= a_stgt;
            fwide <= 1'b1;
            go    <= 1'b1;
            st    <= S_TGT;
          end else if (exhausted) begin
            done    <= 1'b1;
            hit     <= 1'b0;
            bad_tab <= 1'b0;
            new_pc  <= base + FALL_LEN;
            st      <= S_IDLE;
          end else begin
            lo    <= nlo;
            hi    <= nhi;
            mid   <= nmid;
            faddr <= a_next_key;
            fwide <= 1'b1;
            go    <= 1'b1;
          end
        end
        S_TGT: if (fin) begin
          done    <= 1'b1;
          hit     <= 1'b1;
          bad_tab <= 1'b0;
          new_pc  <= base + ua(word);
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swtab_dispatch_chk.sv
module swtab_dispatch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] sw_addr,
  input logic              mem_req,
  input logic              done,
  input logic              hit,
  input logic [ADDR_W-1:0] new_pc,
  input logic              bad_tab
);
  logic              busy;
  logic [ADDR_W-1:0] base_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      base_c <= '0;
    end else if (start && (!busy || done)) begin
      busy   <= 1'b1;
      base_c <= sw_addr;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({hit, bad_tab, new_pc})); // R9
  AST_BAD_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (done && bad_tab) |-> !hit); // R8
  AST_MISS_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (done && !hit) |-> (new_pc == base_c + ADDR_W'(3))); // R5
endmodule

bind swtab_dispatch swtab_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sw_addr(sw_addr),
  .mem_req(mem_req), .done(done), .hit(hit), .new_pc(new_pc),
  .bad_tab(bad_tab)
);

// File: tb/test_swtab_dispatch.sv
module test_swtab_dispatch;
  localparam int AW = 12;
  localparam int MW = 1 << AW;
  localparam int M  = MW - 1;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] sw_addr = '0;
  logic [31:0]   tab_off = '0, test_val = '0;
  logic          mem_valid = 1'b0;
  logic [15:0]   mem_rdata = '0;
  wire           mem_req, done, hit, bad_tab;
  wire  [AW-1:0] mem_addr, new_pc;

  logic [15:0] mem [0:MW-1];
  int checks = 0, errors = 0;
  int nreq = 0, first_a = 0, second_a = 0, ovl = 0;
  bit pend = 1'b0;
  int paddr = 0, cnt = 0;

  always #4 clk = ~clk;

  swtab_dispatch #(.ADDR_W(AW)) i_swtab_dispatch (
    .clk(clk), .rst(rst), .start(start), .sw_addr(sw_addr),
    .tab_off(tab_off), .test_val(test_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .done(done), .hit(hit), .new_pc(new_pc), .bad_tab(bad_tab)
  );

  // Code memory with random read latency
  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[paddr];
        pend = 1'b0;
      end else cnt = cnt - 1;
    end
    if (mem_req) begin
      if (pend) ovl++;
      pend  = 1'b1;
      paddr = int'(mem_addr);
      cnt   = $urandom_range(2, 0);
      nreq++;
      if (nreq == 1) first_a = int'(mem_addr);
      if (nreq == 2) second_a = int'(mem_addr);
    end
  end

  function automatic int rd32(input int a);
    return {mem[(a + 1) & M], mem[a & M]};
  endfunction

  task automatic wr32(input int a, input int v);
    mem[a & M]       = v[15:0];
    mem[(a + 1) & M] = v[31:16];
  endtask

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Expected result from the table contents: linear scan, not a search
  task automatic ref_run(input int sw, input int off, input int key,
                         output bit e_hit, output int e_pc, output bit e_bad,
                         output int e_rmax, output bit e_exact);
    int t, id, n;
    t = (sw + off) & M;
    id = int'(mem[t]);
    n = int'(mem[(t + 1) & M]);
    e_hit = 1'b0; e_bad = 1'b0; e_pc = (sw + 3) & M;
    if (id == 32'h0100) begin
      int d;
      d = key - rd32(t + 2);
      e_exact = 1'b1;
      if (d >= 0 && d < n) begin
        e_hit = 1'b1;
        e_pc = (sw + rd32(t + 4 + 2 * d)) & M;
      end
      e_rmax = e_hit ? 6 : 4;
    end else if (id == 32'h0200) begin
      e_exact = 1'b0;
      for (int i = 0; i < n; i++)
        if (!e_hit && rd32(t + 2 + 2 * i) == key) begin
          e_hit = 1'b1;
          e_pc = (sw + rd32(t + 2 + 2 * n + 2 * i)) & M;
        end
      e_rmax = 2 + 2 * $clog2(n + 1) + (e_hit ? 2 : 0);
    end else begin
      e_bad = 1'b1; e_exact = 1'b1; e_rmax = 1;
    end
  endtask

  task automatic do_case(input int sw, input int off, input int key, input string r);
    bit eh, eb, ex;
    int ep, rmax, w, t;
    ref_run(sw, off, key, eh, ep, eb, rmax, ex);
    t = (sw + off) & M;
    @(negedge clk);
    sw_addr = sw[AW-1:0]; tab_off = off; test_val = key; start = 1'b1;
    nreq = 0; ovl = 0;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(w < 3000, "R9 done seen", w, 0);
    chk(hit == eh, r, int'(hit), int'(eh));
    chk(int'(new_pc) == ep, r, int'(new_pc), ep);
    chk(bad_tab == eb, "R8", int'(bad_tab), int'(eb));
    chk(first_a == t, "R2 first read", first_a, t);
    if (!eb) chk(second_a == ((t + 1) & M), "R2 count read", second_a, (t + 1) & M);
    if (ex) chk(nreq == rmax, "R11 reads", nreq, rmax);
    else    chk(nreq <= rmax, "R11 reads", nreq, rmax);
    chk(ovl == 0, "R10 overlap", ovl, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse", int'(done), 0);
  endtask

  task automatic mk_dense(input int t, input int first, input int n);
    mem[t & M] = 16'h0100; mem[(t + 1) & M] = n[15:0];
    wr32(t + 2, first);
    for (int i = 0; i < n; i++) wr32(t + 4 + 2 * i, int'($urandom));
  endtask

  task automatic mk_sorted(input int t, input int n, input int k0);
    int k;
    k = k0;
    mem[t & M] = 16'h0200; mem[(t + 1) & M] = n[15:0];
    for (int i = 0; i < n; i++) begin
      wr32(t + 2 + 2 * i, k);
      wr32(t + 2 + 2 * n + 2 * i, int'($urandom));
      k = k + int'($urandom_range(5000, 2));
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && hit == 0 && bad_tab == 0 && mem_req == 0, "R1 reset", {done, hit, bad_tab, mem_req}, 0);

    // Unrecognised identifier, then a good lookup
    mem[100] = 16'h0300;
    do_case(90, 10, 5, "R8 bad id");
    mk_dense(200, -3, 8);
    wr32(204, 32'h1234_0005);
    do_case(150, 50, -3, "R4 dense first R3");
    do_case(150, 50, 4, "R4 dense last");
    do_case(150, 50, 5, "R5 dense idx=n");
    do_case(150, 50, -4, "R5 dense negative");
    do_case(150, 50, 32'h7fff_ffff, "R5 dense wrap");
    mk_dense(300, 77, 0);
    do_case(300, 0, 77, "R5 dense empty");

    // Sorted table corners
    mk_sorted(400, 20, -30000);
    do_case(10, 390, rd32(402), "R6 sorted min");
    do_case(10, 390, rd32(402 + 38), "R6 sorted max");
    do_case(10, 390, rd32(402 + 18), "R6 sorted mid");
    do_case(10, 390, rd32(402) - 1, "R7 below min");
    do_case(10, 390, rd32(402 + 38) + 1, "R7 above max");
    do_case(10, 390, rd32(402 + 10) + 1, "R7 between");
    mk_sorted(600, 1, 42);
    do_case(600, 0, 42, "R6 single");
    do_case(600, 0, 43, "R7 single miss");
    mk_sorted(650, 0, 0);
    do_case(650, 0, 0, "R7 sorted empty");

    // Address wrap cases
    mk_dense(10, 1000, 4);
    do_case(4000, -3990, 1002, "R2 negative offset R4");
    mk_dense(710, -1, 3);
    do_case(10, 12988, 0, "R2 large offset R4");
    mk_sorted(4094, 3, -5);
    do_case(4090, 4, rd32(4094 + 2 + 4), "R2 table wraps R6");

    // Random mix
    for (int it = 0; it < 120; it++) begin
      int t, n, sw, off, key, kind;
      t = 2 * int'($urandom_range(1900, 500));
      n = int'($urandom_range(40, 0));
      sw = int'($urandom_range(M, 0));
      off = t - sw + MW * (int'($urandom_range(2, 0)) - 1);
      kind = int'($urandom_range(9, 0));
      if (kind == 0) begin
        mem[t] = 16'($urandom_range(16'hffff, 16'h0300));
        key = int'($urandom);
        do_case(sw, off, key, "R8 random bad");
      end else if (kind < 5) begin
        int first;
        first = int'($urandom);
        mk_dense(t, first, n);
        key = ($urandom_range(1, 0) == 1) ? first + int'($urandom_range(n + 1, 0)) - 1 : int'($urandom);
        do_case(sw, off, key, "R4 R5 random dense");
      end else begin
        mk_sorted(t, n, -int'($urandom_range(100000, 0)));
        if (n > 0 && $urandom_range(1, 0) == 1)
          key = rd32(t + 2 + 2 * int'($urandom_range(n - 1, 0))) + int'($urandom_range(1, 0));
        else key = int'($urandom_range(200000, 0)) - 150000;
        do_case(sw, off, key, "R6 R7 random sorted");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule